// File: doc/BRIEF.md
# Shared Timer Prescaler with Clock Select

This block supplies count-enable strobes to two timer/counter channels. One free-running 10-bit divider is shared by both channels and provides four prescaled taps (divide by 8, 64, 256 and 1024). Each channel also has its own external clock pin. That pin passes through a two-stage synchronizer and then an edge detector whose polarity can be selected.

Each channel has a 3-bit clock-select input. It picks one strobe source: stopped, every system clock, one of the four taps, or a falling or rising edge on the channel's pin. The result is a registered, one-cycle-wide count-enable in the system clock domain. The divider ignores both selects. A single prescaler-clear input restarts its phase for both channels at once.

Cycle c below means the interval after rising clock edge c.

Top module: `tmr_prescale_hub`

## Requirements
- R1: A select of 0 keeps that channel's count-enable low in every cycle.
- R2: A select of 1 drives that channel's count-enable high in every cycle that follows a clock edge at which the select was 1.
- R3: Select values 2, 3, 4 and 5 pick divisors 8, 64, 256 and 1024. The count-enable is high in the cycle after a cycle in which the shared 10-bit divider's value is a multiple of the divisor. Strobes are one cycle wide and exactly one divisor apart.
- R4: The divider runs whatever either select holds. When a channel switches from stopped to a tap of divisor N, the first strobe appears between 1 and N+1 cycles after the cycle in which the select changed.
- R5: Prescaler clear held high in cycle c sets the divider to zero at edge c+1. Every tap channel on either channel then strobes in cycle c+2 and again one divisor later.
- R6: Select 7 gives one strobe per rising edge of the channel's pin, and select 6 gives one strobe per falling edge. An edge of the other polarity gives no strobe.
- R7: The pin is captured on the falling clock edge. A pin change made before the falling edge of cycle c produces its strobe in cycle c+2. A change made after that falling edge produces it in cycle c+3.
- R8: Synchronous active-high reset clears the divider, the synchronizer and the outputs. Count-enables are low during reset. No edge strobe can occur in the first two cycles after release, so a pin that is already high produces nothing.
- R9: The two channels are independent. One channel's select and pin never affect the other channel's count-enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| presc_clr | input | 1 | Restarts the shared divider at zero |
| clk_sel | input | NCH x 3 | Per-channel clock-select code |
| ext_pin | input | NCH | Per-channel external clock pin, asynchronous |
| cnt_en | output | NCH | Per-channel one-cycle count-enable strobe |

## Verification
The assertions assume that the clock-select and prescaler-clear inputs change only between rising edges, with no glitches around the edge. They allow the pins to move at any point in the clock period. The pin assertions also assume the pins are not driven to X once reset has been released. The stimulus changes selects and the clear input one nanosecond after the rising edge. It drives pins either at that point or deliberately after the falling edge, which exercises both latency cases while keeping every pin value clean. A cycle-level reference model in the bench tracks the divider and the synchronizer from the port values and scores every cycle of both channels.

// File: rtl/tmr_prescale_pkg.sv
`timescale 1ns/1ps
package tmr_prescale_pkg;

  // Clock-select codes; the numeric values are part of the block's contract.
  typedef enum logic [2:0] {
    SEL_OFF      = 3'd0,
    SEL_SYS      = 3'd1,
    SEL_DIV8     = 3'd2,
    SEL_DIV64    = 3'd3,
    SEL_DIV256   = 3'd4,
    SEL_DIV1024  = 3'd5,
    SEL_PIN_FALL = 3'd6,
    SEL_PIN_RISE = 3'd7
  } clk_sel_e;

  localparam int NUM_TAPS   = 4;
  localparam int TAP_IDX_W  = $clog2(NUM_TAPS);
  localparam int WARM_CYC   = 2;   // cycles before the edge detector is trusted

  // log2 of the divisor for each tap, lowest divisor first.
  function automatic int tap_log2(input int idx);
    case (idx)
      0:       return 3;
      1:       return 6;
      2:       return 8;
      default: return 10;
    endcase
  endfunction

  // A tap is due when the low tap_log2 bits of the divider are all zero.
  function automatic logic tap_is_due(input int unsigned cnt, input int lg);
    int unsigned mask;
    mask = (32'd1 << lg) - 32'd1;
    return (cnt & mask) == 32'd0;
  endfunction

  // Map a tap select code onto its tap index.
  function automatic logic [TAP_IDX_W-1:0] tap_index(input clk_sel_e sel);
    logic [2:0] off;
    off = 3'(sel) - 3'(SEL_DIV8);
    return off[TAP_IDX_W-1:0];
  endfunction

  function automatic logic is_tap_sel(input clk_sel_e sel);
    return (sel >= SEL_DIV8) && (sel <= SEL_DIV1024);
  endfunction

endpackage

// File: rtl/tmr_prescale_div.sv
`timescale 1ns/1ps
module tmr_prescale_div
  import tmr_prescale_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  output logic [NUM_TAPS-1:0] tap_due_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             restart;

  assign restart = rst | clr;

  // Free-running divider: only reset or the prescaler clear touch its phase.
  always_ff @(posedge clk) begin
    if (restart) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
    assign tap_due_o[k] = tap_is_due(32'(cnt_q), tap_log2(k));
  end

  // R3: the divider advances by one on every edge without a clear
  a_r3_free_run: assert property (@(posedge clk) disable iff (rst)
    !clr |=> cnt_q == $past(cnt_q) + 1'b1);

  // R5: after a clear every tap is due at once
  a_r5_clear_phase: assert property (@(posedge clk) disable iff (rst)
    clr |=> tap_due_o == '1);

  for (genvar k = 1; k < NUM_TAPS; k++) begin : g_nest
    // R3: a slower tap only fires on a cycle where every faster tap fires
    a_r3_tap_nested: assert property (@(posedge clk) disable iff (rst)
      tap_due_o[k] |-> tap_due_o[k-1]);
  end

endmodule

// File: rtl/tmr_pin_edge.sv
`timescale 1ns/1ps
module tmr_pin_edge
  import tmr_prescale_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise_o,
  output logic fall_o
);

  localparam int WARM_W = $clog2(WARM_CYC + 1);

  logic              smp_n;    // falling-edge capture (half-cycle stage)
  logic              sync_q;   // rising-edge synchronized value
  logic              prev_q;   // previous synchronized value
  logic [WARM_W-1:0] warm_q;
  logic              armed;

  always_ff @(negedge clk) begin
    if (rst) smp_n <= 1'b0;
    else     smp_n <= pin;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= 1'b0;
      prev_q <= 1'b0;
      warm_q <= '0;
    end else begin
      sync_q <= smp_n;
      prev_q <= sync_q;
      if (warm_q != WARM_W'(WARM_CYC)) warm_q <= warm_q + 1'b1;
    end
  end

  // Both history stages hold real pin samples only once warm-up is done.
  assign armed  = (warm_q == WARM_W'(WARM_CYC));
  assign rise_o = armed &  sync_q & ~prev_q;
  assign fall_o = armed & ~sync_q &  prev_q;

  // R6: one edge kind at a time
  a_r6_one_kind: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rise_o, fall_o}));

  // R6: a detected edge is never reported on two consecutive cycles
  a_r6_rise_single: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);
  a_r6_fall_single: assert property (@(posedge clk) disable iff (rst)
    fall_o |=> !fall_o);

  // R8: the first cycle after reset release never reports an edge
  a_r8_quiet_release: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !rise_o && !fall_o);

endmodule

// File: rtl/tmr_clk_select.sv
`timescale 1ns/1ps
module tmr_clk_select
  import tmr_prescale_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [2:0]          sel_i,
  input  logic [NUM_TAPS-1:0] tap_due_i,
  input  logic                rise_i,
  input  logic                fall_i,
  output logic                stb_o
);

  clk_sel_e sel;
  logic     pick;
  logic     stb_q;

  assign sel = clk_sel_e'(sel_i);

  always_comb begin
    pick = 1'b0;
    case (sel)
      SEL_OFF:      pick = 1'b0;
      SEL_SYS:      pick = 1'b1;
      SEL_PIN_FALL: pick = fall_i;
      SEL_PIN_RISE: pick = rise_i;
      default:      pick = is_tap_sel(sel) ? tap_due_i[tap_index(sel)] : 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) stb_q <= 1'b0;
    else     stb_q <= pick;
  end

  assign stb_o = stb_q;

  // R1: a stopped channel stays silent
  a_r1_off_silent: assert property (@(posedge clk) disable iff (rst)
    sel == SEL_OFF |=> !stb_o);

  // R2: full-rate select strobes on the next cycle
  a_r2_sys_rate: assert property (@(posedge clk) disable iff (rst)
    sel == SEL_SYS |=> stb_o);

  // R6: an opposite-polarity edge produces nothing
  a_r6_wrong_edge: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_PIN_RISE && fall_i) |=> !stb_o);

endmodule

// File: rtl/tmr_prescale_hub.sv
`timescale 1ns/1ps
module tmr_prescale_hub
  import tmr_prescale_pkg::*;
#(
  parameter int NCH   = 2,
  parameter int CNT_W = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                presc_clr,
  input  logic [NCH-1:0][2:0] clk_sel,
  input  logic [NCH-1:0]      ext_pin,
  output logic [NCH-1:0]      cnt_en
);

  logic [NUM_TAPS-1:0] tap_due;
  logic [NCH-1:0]      pin_rise;
  logic [NCH-1:0]      pin_fall;

  tmr_prescale_div #(.CNT_W(CNT_W)) u_div (
    .clk       (clk),
    .rst       (rst),
    .clr       (presc_clr),
    .tap_due_o (tap_due)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tmr_pin_edge u_edge (
      .clk    (clk),
      .rst    (rst),
      .pin    (ext_pin[c]),
      .rise_o (pin_rise[c]),
      .fall_o (pin_fall[c])
    );

    tmr_clk_select u_sel (
      .clk       (clk),
      .rst       (rst),
      .sel_i     (clk_sel[c]),
      .tap_due_i (tap_due),
      .rise_i    (pin_rise[c]),
      .fall_i    (pin_fall[c]),
      .stb_o     (cnt_en[c])
    );
  end

  // R8: outputs are low in the cycle after a reset edge
  a_r8_reset_quiet: assert property (@(posedge clk)
    rst |=> cnt_en == '0);

endmodule

// File: tb/tmr_prescale_hub_tb_top.sv
`timescale 1ns/1ps
module tmr_prescale_hub_tb_top;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            presc_clr = 1'b0;
  logic [1:0][2:0] cs = '0;
  logic [1:0]      pin = 2'b11;
  logic [1:0]      cnt_en;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #2.5 clk = ~clk;   // 200 MHz

  tmr_prescale_hub #(.NCH(2), .CNT_W(10)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .presc_clr (presc_clr),
    .clk_sel   (cs),
    .ext_pin   (pin),
    .cnt_en    (cnt_en)
  );

  task automatic chk(input string req, input logic ok, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  // ---------------- scoreboard: reference model + queue ----------------
  typedef struct {
    logic [1:0]      exp;
    logic [1:0][2:0] sel;
    logic            in_rst;
    int              at;
  } sb_item_t;

  sb_item_t   sbq[$];
  logic [1:0] m_cap;
  logic [1:0] m_s1 = '0;
  logic [1:0] m_s2 = '0;
  int         m_cnt = 0;
  int         m_warm = 0;

  always @(negedge clk) m_cap <= pin;

  function automatic int divisor(input logic [2:0] s);
    case (s)
      3'd2:    return 8;
      3'd3:    return 64;
      3'd4:    return 256;
      default: return 1024;
    endcase
  endfunction

  always @(posedge clk) begin : model
    sb_item_t it;
    cyc++;
    it.sel = cs;
    it.in_rst = rst;
    it.at = cyc;
    it.exp = '0;
    if (rst) begin
      m_cnt = 0; m_s1 = '0; m_s2 = '0; m_warm = 0;
    end else begin
      for (int c = 0; c < 2; c++) begin
        case (cs[c])
          3'd0: it.exp[c] = 1'b0;
          3'd1: it.exp[c] = 1'b1;
          3'd6: it.exp[c] = (m_warm >= 2) && !m_s1[c] && m_s2[c];
          3'd7: it.exp[c] = (m_warm >= 2) && m_s1[c] && !m_s2[c];
          default: it.exp[c] = (m_cnt % divisor(cs[c])) == 0;
        endcase
      end
      m_cnt = presc_clr ? 0 : (m_cnt + 1) % 1024;
      m_s2 = m_s1;
      m_s1 = m_cap;
      if (m_warm < 2) m_warm++;
    end
    sbq.push_back(it);
  end

  function automatic string req_of(input logic r, input logic [2:0] s);
    if (r) return "R8";
    case (s)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd6, 3'd7: return "R6";
      default: return "R3";
    endcase
  endfunction

  always begin : monitor
    sb_item_t it;
    @(posedge clk);
    #4;
    if (sbq.size() > 0) begin
      it = sbq.pop_front();
      for (int c = 0; c < 2; c++)
        chk({req_of(it.in_rst, it.sel[c]), "/R9 ch", (c == 0) ? "0" : "1"},
            cnt_en[c] === it.exp[c], int'(cnt_en[c]), int'(it.exp[c]));
    end
  end

  // ---------------- driver helpers ----------------
  task automatic wait_cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic sample_next(output logic [1:0] v);
    wait_cyc();
    #3;
    v = cnt_en;
  endtask

  task automatic skip(input int n);
    for (int i = 0; i < n; i++) wait_cyc();
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // ---------------- directed sequence ----------------
  initial begin
    logic [1:0] v;
    int first, gap, rises0, falls1, hits0, hits1;
    logic [1:0] oldp;

    cs[0] = 3'd7; cs[1] = 3'd6;
    skip(3);
    #3;
    chk("R8 outputs in reset", cnt_en == 2'b00, int'(cnt_en), 0);
    wait_cyc();
    rst = 1'b0;                       // pin already high
    for (int i = 0; i < 5; i++) begin
      sample_next(v);
      chk("R8 no strobe after release", v == 2'b00, int'(v), 0);
    end

    // R7: change before the falling edge -> strobe two cycles later
    cs[1] = 3'd6;
    skip(2);
    pin[1] = 1'b0;
    sample_next(v);
    chk("R7 early edge not at c+1", v[1] == 1'b0, int'(v[1]), 0);
    sample_next(v);
    chk("R7 early edge at c+2", v[1] == 1'b1, int'(v[1]), 1);

    // R7: change after the falling edge -> strobe three cycles later
    cs[1] = 3'd7;
    skip(3);
    #2.5;
    pin[1] = 1'b1;
    #0.5;
    sample_next(v);
    chk("R7 late edge not at c+1", v[1] == 1'b0, int'(v[1]), 0);
    sample_next(v);
    chk("R7 late edge not at c+2", v[1] == 1'b0, int'(v[1]), 0);
    sample_next(v);
    chk("R7 late edge at c+3", v[1] == 1'b1, int'(v[1]), 1);

    // R2 and R9: full rate on ch0 while ch1 is stopped
    cs[0] = 3'd1; cs[1] = 3'd0;
    sample_next(v);
    for (int i = 0; i < 20; i++) begin
      sample_next(v);
      chk("R2 full rate ch0", v[0] == 1'b1, int'(v[0]), 1);
      chk("R9 ch1 unaffected", v[1] == 1'b0, int'(v[1]), 0);
    end

    // R4: first strobe window from enable, two different phases
    for (int rep = 0; rep < 2; rep++) begin
      cs[0] = 3'd0;
      skip(3 + rep * 17);
      cs[0] = 3'd3;
      first = 0;
      for (int k = 1; k <= 200; k++) begin
        sample_next(v);
        if (v[0]) begin first = k; break; end
      end
      chk("R4 first strobe within 1..65", first >= 1 && first <= 65, first, 65);
    end

    // R3: strobe period for each tap
    for (int t = 0; t < 4; t++) begin
      cs[0] = 3'(2 + t);
      sample_next(v);
      for (int k = 0; k < 1100; k++) begin
        sample_next(v);
        if (v[0]) break;
      end
      gap = 0;
      for (int k = 1; k <= 1100; k++) begin
        sample_next(v);
        if (v[0]) begin gap = k; break; end
      end
      chk("R3 tap period", gap == divisor(3'(2 + t)), gap, divisor(3'(2 + t)));
    end

    // R5: prescaler clear aligns both channels
    cs[0] = 3'd4; cs[1] = 3'd5;
    skip(37);
    presc_clr = 1'b1;
    sample_next(v);
    presc_clr = 1'b0;
    sample_next(v);
    chk("R5 both strobe at c+2", v == 2'b11, int'(v), 3);
    gap = 0;
    for (int k = 1; k <= 300; k++) begin
      sample_next(v);
      if (v[0]) begin gap = k; break; end
    end
    chk("R5 next div256 strobe", gap == 256, gap, 256);

    // R6: random pin activity, ch0 rising, ch1 falling
    cs[0] = 3'd7; cs[1] = 3'd6;
    skip(4);
    rises0 = 0; falls1 = 0; hits0 = 0; hits1 = 0;
    for (int i = 0; i < 400; i++) begin
      oldp = pin;
      pin = 2'($urandom_range(0, 3));
      if (!oldp[0] && pin[0]) rises0++;
      if (oldp[1] && !pin[1]) falls1++;
      #3;
      hits0 += int'(cnt_en[0]);
      hits1 += int'(cnt_en[1]);
      wait_cyc();
    end
    for (int i = 0; i < 4; i++) begin
      #3;
      hits0 += int'(cnt_en[0]);
      hits1 += int'(cnt_en[1]);
      wait_cyc();
    end
    chk("R6 rising edges counted ch0", hits0 == rises0, hits0, rises0);
    chk("R6 falling edges counted ch1", hits1 == falls1, hits1, falls1);

    // R1: stopped channels ignore pin activity
    cs[0] = 3'd0; cs[1] = 3'd0;
    hits0 = 0;
    skip(2);
    for (int i = 0; i < 100; i++) begin
      pin = ~pin;
      #3;
      hits0 += int'(cnt_en[0]) + int'(cnt_en[1]);
      wait_cyc();
    end
    chk("R1 stopped channels silent", hits0 == 0, hits0, 0);

    skip(3);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule